// File: doc/BRIEF.md
# Fractional-Step Baud Tick Generator

This block turns the system clock into a single-cycle bit-rate enable. The rate is set in two stages. An integer prescaler first divides the clock by `scale+1`. Each prescaler pulse then adds `step` into a phase accumulator one bit wider than the step. A tick is issued whenever that addition carries out of the accumulator's top bit. With the default widths, the tick rate is clk / (scale+1) × step / 2^17. This gives fine rate resolution without a long integer divider.

Both settings arrive in one 32-bit configuration word, written with a single-cycle strobe. Every write restarts the prescaler and the accumulator, so the first tick after a write comes a full period later. A separate enable freezes the whole generator without losing its phase. The tick is meant to drive the bit timing of serial shifters. The shifters and any receive oversampling sit outside this block.

Top module: `frac_baud_tick`

## Requirements
- R1: During reset and after it, `tick` is low. Reset sets both settings to zero, so no tick appears until the configuration is written.
- R2: A configuration is captured at a rising edge where `cfg_wr` is high. Scale is taken from `cfg_word[27:16]` and step from `cfg_word[15:0]`. Bits [31:28] have no effect.
- R3: With `en` high, the accumulator advances once every scale+1 clocks. A scale of 0 advances it on every enabled clock.
- R4: Each advance adds step to a (STEP_W+1)-bit accumulator, modulo 2^(STEP_W+1). The tick is high for exactly the one cycle that follows an advance whose sum carries out of the top bit. With the write at edge 0 and `en` held high, the tick is high after edge n if and only if both of these hold: n is a multiple of scale+1, and floor(m·step/2^(STEP_W+1)) > floor((m−1)·step/2^(STEP_W+1)), where m = n/(scale+1).
- R5: Over 2^(STEP_W+1)·(scale+1) enabled clocks following a write, exactly `step` ticks are produced.
- R6: A step of 0 never produces a tick.
- R7: A write clears the prescaler, the accumulator and the tick. The tick is low in the cycle after the write edge, and the sequence of R4 restarts, counted from that edge.
- R8: At an edge where `en` is low, the prescaler and the accumulator hold their values and the tick is low in the following cycle. When `en` returns, counting resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low freezes the generator |
| cfg_wr | input | 1 | Single-cycle configuration write strobe |
| cfg_word | input | 32 | Configuration word: scale in [27:16], step in [15:0] |
| tick | output | 1 | Single-cycle bit-rate enable |

## Verification
The bench builds two copies of the block, at the same time.

The first uses the default 12-bit scale and 16-bit step. It runs a complete 2^17-clock window at scale 0, which shows the exact tick count at full width. It also checks the bit-field placement in the configuration word, including that the top nibble is ignored.

The second is built with SCALE_W=3 and STEP_W=4, which gives a 5-bit accumulator. Its full period is at most 256 clocks, so every scale and step pair can be swept. Each pair is checked cycle by cycle against the closed-form tick position, and also for its exact count over one period. On this small copy, the bench also exercises a restart in the middle of a run and an enable gap.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int CFG_W        = 32;
  localparam int CFG_STEP_LSB = 0;
  localparam int CFG_SCALE_LSB = 16;
  localparam int SCALE_W_MAX  = 12;
  localparam int STEP_W_MAX   = 16;
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg
  import fbg_pkg::*;
#(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic [SCALE_W-1:0] scale_q,
  output logic [STEP_W-1:0]  step_q
);
  function automatic logic [SCALE_W-1:0] pick_scale(input logic [CFG_W-1:0] w);
    return w[CFG_SCALE_LSB +: SCALE_W];
  endfunction

  function automatic logic [STEP_W-1:0] pick_step(input logic [CFG_W-1:0] w);
    return w[CFG_STEP_LSB +: STEP_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      step_q  <= '0;
    end else if (cfg_wr) begin
      scale_q <= pick_scale(cfg_word);
      step_q  <= pick_step(cfg_word);
    end
  end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               clr,
  input  logic [SCALE_W-1:0] scale,
  output logic               adv
);
  logic [SCALE_W-1:0] cnt;
  logic               at_end;

  assign at_end = (cnt == scale);
  assign adv    = en & ~clr & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en)     cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STEP_W-1:0] step,
  output logic              carry,
  output logic              tick
);
  localparam int ACC_W = STEP_W + 1;

  function automatic logic [ACC_W:0] acc_sum(input logic [ACC_W-1:0] a,
                                             input logic [STEP_W-1:0] s);
    return {1'b0, a} + {2'b00, s};
  endfunction

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   nxt;

  assign nxt   = acc_sum(acc, step);
  assign carry = nxt[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= adv & carry;
      if (adv) acc <= nxt[ACC_W-1:0];
    end
  end
endmodule

// File: rtl/frac_baud_tick.sv
module frac_baud_tick
  import fbg_pkg::*;
#(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_word,
  output logic        tick
);
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;
  logic               adv;
  logic               carry;

  fbg_cfg_reg #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .scale_q(scale_q), .step_q(step_q)
  );

  fbg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(cfg_wr),
    .scale(scale_q), .adv(adv)
  );

  fbg_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .adv(adv),
    .step(step_q), .carry(carry), .tick(tick)
  );
endmodule

// File: rtl/frac_baud_tick_chk.sv
module frac_baud_tick_chk #(
  parameter int SCALE_W = 12,
  parameter int STEP_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               cfg_wr,
  input logic               adv,
  input logic               carry,
  input logic               tick,
  input logic [SCALE_W-1:0] scale_q,
  input logic [STEP_W-1:0]  step_q
);
  assert_scale0_every_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_wr && scale_q == '0) |-> adv);

  assert_adv_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && scale_q != '0 && !cfg_wr) |=> !adv);

  assert_tick_after_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(adv) && $past(carry)));

  assert_zero_step_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step_q) == '0) |-> !tick);

  assert_write_quiets_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tick);

  assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !adv);

  assert_off_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick);
endmodule

bind frac_baud_tick frac_baud_tick_chk #(.SCALE_W(SCALE_W), .STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .adv(adv),
  .carry(carry), .tick(tick), .scale_q(scale_q), .step_q(step_q)
);

// File: tb/frac_baud_tick_tb.sv
module frac_baud_tick_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_b = 1'b0, wr_b = 1'b0, tick_b;
  logic en_s = 1'b0, wr_s = 1'b0, tick_s;
  logic [31:0] word_b = '0, word_s = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_baud_tick u_dut (
    .clk(clk), .rst_n(rst_n), .en(en_b), .cfg_wr(wr_b),
    .cfg_word(word_b), .tick(tick_b)
  );

  frac_baud_tick #(.SCALE_W(3), .STEP_W(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .en(en_s), .cfg_wr(wr_s),
    .cfg_word(word_s), .tick(tick_s)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_tick(input longint n, input longint s, input longint st, input int accw);
    longint m;
    if (n % (s + 1) != 0) return 1'b0;
    m = n / (s + 1);
    return ((m * st) >> accw) != (((m - 1) * st) >> accw);
  endfunction

  // Writes the word, then checks tick after each of `total` enabled edges
  // (plus an optional gap of disabled edges starting at enabled count gap_at).
  task automatic run_cfg(input bit big, input logic [31:0] word, input longint s,
                         input longint st, input int total, input int gap_at,
                         input int gap_len, input longint exp_cnt, input string tag);
    longint n = 0;
    longint ticks = 0;
    int bad = 0;
    int accw = big ? 17 : 5;
    logic t;
    @(negedge clk);
    if (big) begin word_b = word; wr_b = 1'b1; en_b = 1'b1; end
    else     begin word_s = word; wr_s = 1'b1; en_s = 1'b1; end
    @(negedge clk);
    if (big) wr_b = 1'b0; else wr_s = 1'b0;
    t = big ? tick_b : tick_s;
    check(t == 1'b0, {tag, " R7 tick low after write"}, t, 0);
    for (int c = 0; c < total + gap_len; c++) begin
      bit in_gap = (gap_at >= 0) && (c >= gap_at) && (c < gap_at + gap_len);
      bit e;
      if (big) en_b = !in_gap; else en_s = !in_gap;
      @(negedge clk);
      t = big ? tick_b : tick_s;
      if (!in_gap) n++;
      e = in_gap ? 1'b0 : exp_tick(n, s, st, accw);
      if (t != e) begin
        if (bad == 0)
          $display("FAIL %s R4 edge %0d: actual %0d expected %0d", tag, n, t, e);
        bad++;
      end
      if (t) ticks++;
    end
    if (big) en_b = 1'b1; else en_s = 1'b1;
    check(bad == 0, {tag, " R3 R4 per-cycle pattern"}, bad, 0);
    if (exp_cnt >= 0)
      check(ticks == exp_cnt, {tag, " R5 tick count"}, ticks, exp_cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tick_b == 1'b0 && tick_s == 1'b0, "R1 tick low in reset", {tick_b, tick_s}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    en_b = 1'b1;
    en_s = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tick_b || tick_s) seen++;
      end
      check(seen == 0, "R1 R6 no tick before first write", seen, 0);
    end

    // Exhaustive sweep on the small build
    for (int s = 0; s < 8; s++) begin
      for (int st = 0; st < 16; st++) begin
        string tag;
        tag = $sformatf("small s=%0d st=%0d%s", s, st, (st == 0) ? " R6" : "");
        run_cfg(1'b0, (32'(s) << 16) | 32'(st), s, st, 32 * (s + 1), -1, 0, st, tag);
      end
    end

    // R2: bits outside the fields ignored (small build: only low field bits used)
    run_cfg(1'b0, 32'hFFF9_FFF5, 1, 5, 64, -1, 0, 5, "R2 small ignored bits");

    // R7: restart mid-run
    run_cfg(1'b0, (32'd1 << 16) | 32'd7, 1, 7, 21, -1, 0, -1, "R7 partial");
    run_cfg(1'b0, (32'd1 << 16) | 32'd7, 1, 7, 64, -1, 0, 7, "R7 restart");

    // R8: enable gap in the middle of a period
    run_cfg(1'b0, (32'd2 << 16) | 32'd11, 2, 11, 96, 17, 13, 11, "R8 gap scale2");
    run_cfg(1'b0, 32'd9, 0, 9, 32, 5, 7, 9, "R8 gap scale0");

    // Default build: field placement with top nibble set, then a full window
    run_cfg(1'b1, 32'hF000_0000 | (32'd2 << 16) | 32'h0000_FFFF, 2, 65535, 60, -1, 0, -1,
            "R2 default top nibble");
    run_cfg(1'b1, 32'h0000_1234, 0, 32'h1234, 131072, -1, 0, 32'h1234, "R5 default full window");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule